// File: doc/BRIEF.md
# Flash Sector Erase Sequencer

This controller sits on the host side of an asynchronous parallel flash bus. It starts a sector erase from a single request. On `start_i` it captures the sector address into a private holding register. It then requests the bus and, once granted, issues the six write cycles that launch an erase. After that it gives the bus up so that other masters can use it for the whole erase time, which may be seconds.

Every poll interval the controller requests the bus again and runs one read cycle. The read always uses the held sector address, because the flash stops latching an address once its erase has finished. Bit 7 of the read data shows completion. When it reads 1, the controller pulses `done_o` and returns to idle. If the overall time limit runs out first, it pulses `timeout_o` instead and returns to idle. A reset stops the sequence. The sector is then undefined, and the system must issue the erase again from the beginning.

Top module: `erase_seq`

## Requirements
- R1: In idle, a high `start_i` captures `sector_addr_i`. On the next clock the controller raises `busy_o` and `bus_req_o`. No strobe goes low before `bus_gnt_i` is seen high.
- R2: The launch is exactly six write cycles, in this order of (address, data): (UNLOCK1_ADDR, 0xAA), (UNLOCK2_ADDR, 0x55), (UNLOCK1_ADDR, 0x80), (UNLOCK1_ADDR, 0xAA), (UNLOCK2_ADDR, 0x55), (sector address, 0x30). The defaults are UNLOCK1_ADDR = 0x555 and UNLOCK2_ADDR = 0x2AA.
- R3: In every write, address and data are driven at least one clock before `bus_we_n_o` falls. `bus_we_n_o` stays low for exactly STROBE_CLKS clocks. Address and data stay stable while it is low, and the data stays driven in the clock in which it rises.
- R4: While `bus_req_o` is low, both strobes are high and `bus_wdata_oe_o` is low. Between the end of one bus transaction and the next poll request, `bus_req_o` stays low for exactly POLL_GAP_CLKS+1 clocks.
- R5: Each poll is a read cycle at the held sector address. `bus_oe_n_o` is low for exactly STROBE_CLKS clocks and the data output is not driven.
- R6: A poll whose read data has bit 7 = 1 ends the erase. `done_o` goes high for one clock, together with `busy_o` and `bus_req_o` low. A poll with bit 7 = 0 leads to another poll. The other data bits are ignored.
- R7: If no poll has seen completion by TIMEOUT_CLKS clocks after the sixth write, the controller gives up. `timeout_o` goes high for one clock between TIMEOUT_CLKS+2 and TIMEOUT_CLKS+STROBE_CLKS+6 clocks after the sixth strobe rises. The controller then returns to idle with no `done_o`.
- R8: `start_i` while busy is ignored. The polls keep using the address captured at the start.
- R9: Reset, asserted at any time, forces idle with the bus released and strobes high. The next start runs the complete six-write launch again.
- R10: The two strobes are never low together, and a strobe is low only while `bus_req_o` and `bus_gnt_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to erase one sector |
| sector_addr_i | input | ADDR_W | Any address inside the sector to erase |
| busy_o | output | 1 | Erase sequence in progress |
| done_o | output | 1 | One-clock pulse: erase finished |
| timeout_o | output | 1 | One-clock pulse: time limit reached |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant, held while the request stays high |
| bus_addr_o | output | ADDR_W | Flash address |
| bus_wdata_o | output | 8 | Write data |
| bus_wdata_oe_o | output | 1 | Write data output enable |
| bus_we_n_o | output | 1 | Active-low write strobe |
| bus_oe_n_o | output | 1 | Active-low read strobe |
| bus_rdata_i | input | 8 | Read data from the flash |

## Verification
Some rules are checked by the assertions on every clock:
- the strobes never overlap, and a strobe is low only when the bus is owned;
- the bus is quiet while it is not requested;
- address and data are stable under a strobe, and write data is held when the strobe rises;
- the pulse outputs last one clock and never occur together;
- the held sector address does not change when a start arrives while busy.

Other behaviour only the bench scenarios can show:
- the order and contents of the six launch writes and the exact strobe width;
- the exact poll gap;
- the number of polls before completion is seen;
- the timeout latency;
- the complete relaunch after a mid-erase reset.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD_REQ,
    S_CMD_XFER,
    S_WAIT,
    S_POLL_REQ,
    S_POLL_XFER
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_RECOV
  } bus_phase_e;

  localparam int unsigned CMD_STEPS  = 6;
  localparam int unsigned STEP_W     = $clog2(CMD_STEPS);
  localparam int unsigned STATUS_BIT = 7;
  localparam int unsigned DATA_W     = 8;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;
  localparam logic [DATA_W-1:0] ERASE_ARM  = 8'h80;
  localparam logic [DATA_W-1:0] SECTOR_GO  = 8'h30;

endpackage

// File: rtl/erase_cmd_gen.sv
module erase_cmd_gen
  import erase_seq_pkg::*;
#(
  parameter int unsigned        ADDR_W       = 20,
  parameter logic [ADDR_W-1:0]  UNLOCK1_ADDR = ADDR_W'('h555),
  parameter logic [ADDR_W-1:0]  UNLOCK2_ADDR = ADDR_W'('h2AA)
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W-1:0] sector_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  // R2: launch order, the last write carries the sector address
  always_comb begin
    case (step_i)
      STEP_W'(0): begin addr_o = UNLOCK1_ADDR; data_o = KEY_FIRST;  end
      STEP_W'(1): begin addr_o = UNLOCK2_ADDR; data_o = KEY_SECOND; end
      STEP_W'(2): begin addr_o = UNLOCK1_ADDR; data_o = ERASE_ARM;  end
      STEP_W'(3): begin addr_o = UNLOCK1_ADDR; data_o = KEY_FIRST;  end
      STEP_W'(4): begin addr_o = UNLOCK2_ADDR; data_o = KEY_SECOND; end
      default:    begin addr_o = sector_i;     data_o = SECTOR_GO;  end
    endcase
  end

endmodule

// File: rtl/erase_interval_cnt.sv
module erase_interval_cnt #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic expired_o
);

  localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)             cnt_d = '0;
    else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == LIM);

  // R7: once expired, the interval stays expired until cleared
  a_r7_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !clr_i) |=> expired_o);

endmodule

// File: rtl/erase_bus_phy.sv
module erase_bus_phy
  import erase_seq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned STROBE_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  input  logic [DATA_W-1:0] rdata_i
);

  localparam int unsigned SW = (STROBE_CLKS < 2) ? 1 : $clog2(STROBE_CLKS);
  localparam logic [SW-1:0] LAST = SW'(STROBE_CLKS - 1);

  bus_phase_e        ph_q, ph_d;
  logic [SW-1:0]     cnt_q, cnt_d;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, rdata_q;
  logic              load_en, cap_en;

  assign load_en = go_i && ((ph_q == PH_IDLE) || (ph_q == PH_RECOV));
  assign cap_en  = (ph_q == PH_PULSE) && (cnt_q == LAST) && rd_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    case (ph_q)
      PH_IDLE:  if (go_i) ph_d = PH_SETUP;
      PH_SETUP: begin ph_d = PH_PULSE; cnt_d = '0; end
      PH_PULSE: begin
        if (cnt_q == LAST) ph_d = PH_RECOV;
        else               cnt_d = cnt_q + 1'b1;
      end
      default:  ph_d = go_i ? PH_SETUP : PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (load_en) begin
      rd_q   <= rd_i;
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= rdata_i;
  end

  assign done_o    = (ph_q == PH_RECOV);
  assign rdata_o   = rdata_q;
  assign addr_o    = addr_q;
  assign data_o    = data_q;
  assign data_oe_o = (ph_q != PH_IDLE) && !rd_q;
  assign we_n_o    = !((ph_q == PH_PULSE) && !rd_q);
  assign oe_n_o    = !((ph_q == PH_PULSE) && rd_q);

  // R3 / R5: address and data stay put under a strobe
  a_r3_stable_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n_o || !oe_n_o) |-> ($stable(addr_o) && $stable(data_o)));

  // R3: data set up before the write strobe falls
  a_r3_data_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n_o) |-> $past(data_oe_o));

  // R3: data still driven when the write strobe rises
  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_o) |-> data_oe_o);

  // R10: strobes never overlap
  a_r10_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_o && !oe_n_o));

endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_seq_pkg::*;
#(
  parameter int unsigned       ADDR_W        = 20,
  parameter int unsigned       STROBE_CLKS   = 3,
  parameter int unsigned       POLL_GAP_CLKS = 125_000,
  parameter int unsigned       TIMEOUT_CLKS  = 32'd3_750_000_000,
  parameter logic [ADDR_W-1:0] UNLOCK1_ADDR  = ADDR_W'('h555),
  parameter logic [ADDR_W-1:0] UNLOCK2_ADDR  = ADDR_W'('h2AA)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] sector_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  output logic              bus_wdata_oe_o,
  output logic              bus_we_n_o,
  output logic              bus_oe_n_o,
  input  logic [7:0]        bus_rdata_i
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(CMD_STEPS - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d, cmd_step;
  logic [ADDR_W-1:0] sect_q;
  logic              sect_ld;
  logic              done_q, done_d, tout_q, tout_d;
  logic              phy_go, phy_rd, phy_done;
  logic [DATA_W-1:0] phy_rdata;
  logic [ADDR_W-1:0] cmd_addr, phy_addr;
  logic [DATA_W-1:0] cmd_data;
  logic              gap_clr, gap_exp, to_clr, to_exp;

  erase_cmd_gen #(
    .ADDR_W       (ADDR_W),
    .UNLOCK1_ADDR (UNLOCK1_ADDR),
    .UNLOCK2_ADDR (UNLOCK2_ADDR)
  ) u_cmd (
    .step_i   (cmd_step),
    .sector_i (sect_q),
    .addr_o   (cmd_addr),
    .data_o   (cmd_data)
  );

  assign phy_addr = phy_rd ? sect_q : cmd_addr;

  erase_bus_phy #(
    .ADDR_W      (ADDR_W),
    .STROBE_CLKS (STROBE_CLKS)
  ) u_phy (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .go_i      (phy_go),
    .rd_i      (phy_rd),
    .addr_i    (phy_addr),
    .data_i    (cmd_data),
    .done_o    (phy_done),
    .rdata_o   (phy_rdata),
    .addr_o    (bus_addr_o),
    .data_o    (bus_wdata_o),
    .data_oe_o (bus_wdata_oe_o),
    .we_n_o    (bus_we_n_o),
    .oe_n_o    (bus_oe_n_o),
    .rdata_i   (bus_rdata_i)
  );

  erase_interval_cnt #(.LIMIT(POLL_GAP_CLKS)) u_gap (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_i     (gap_clr),
    .expired_o (gap_exp)
  );

  erase_interval_cnt #(.LIMIT(TIMEOUT_CLKS)) u_limit (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_i     (to_clr),
    .expired_o (to_exp)
  );

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    cmd_step = step_q;
    sect_ld  = 1'b0;
    phy_go   = 1'b0;
    phy_rd   = 1'b0;
    gap_clr  = 1'b0;
    to_clr   = 1'b0;
    done_d   = 1'b0;
    tout_d   = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start_i) begin
          sect_ld = 1'b1;
          step_d  = '0;
          state_d = S_CMD_REQ;
        end
      end
      S_CMD_REQ: begin
        if (bus_gnt_i) begin
          cmd_step = '0;
          phy_go   = 1'b1;
          state_d  = S_CMD_XFER;
        end
      end
      S_CMD_XFER: begin
        if (phy_done) begin
          if (step_q == LAST_STEP) begin
            gap_clr = 1'b1;
            to_clr  = 1'b1;
            state_d = S_WAIT;
          end else begin
            cmd_step = step_q + 1'b1;
            step_d   = step_q + 1'b1;
            phy_go   = 1'b1;
          end
        end
      end
      S_WAIT: begin
        if (to_exp) begin
          tout_d  = 1'b1;
          state_d = S_IDLE;
        end else if (gap_exp) begin
          state_d = S_POLL_REQ;
        end
      end
      S_POLL_REQ: begin
        if (to_exp) begin
          tout_d  = 1'b1;
          state_d = S_IDLE;
        end else if (bus_gnt_i) begin
          phy_go  = 1'b1;
          phy_rd  = 1'b1;
          state_d = S_POLL_XFER;
        end
      end
      S_POLL_XFER: begin
        if (phy_done) begin
          if (phy_rdata[STATUS_BIT]) begin
            done_d  = 1'b1;
            state_d = S_IDLE;
          end else begin
            gap_clr = 1'b1;
            state_d = S_WAIT;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= done_d;
      tout_q  <= tout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   sect_q <= '0;
    else if (sect_ld) sect_q <= sector_addr_i;
  end

  assign busy_o    = (state_q != S_IDLE);
  assign bus_req_o = (state_q == S_CMD_REQ)  || (state_q == S_CMD_XFER) ||
                     (state_q == S_POLL_REQ) || (state_q == S_POLL_XFER);
  assign done_o    = done_q;
  assign timeout_o = tout_q;

  // R1: a new sequence asks for the bus at once
  a_r1_req_on_start: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(busy_o) |-> bus_req_o);

  // R10: strobes only while the bus is owned
  a_r10_strobe_owned: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!bus_we_n_o || !bus_oe_n_o) |-> (bus_req_o && bus_gnt_i));

  // R4: released bus is left quiet
  a_r4_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_req_o |-> (bus_we_n_o && bus_oe_n_o && !bus_wdata_oe_o));

  // R6: completion is a single pulse seen from idle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> !done_o);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> (!busy_o && !bus_req_o));

  // R7: give-up is a single pulse, never together with completion
  a_r7_timeout_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    timeout_o |=> !timeout_o);
  a_r7_exclusive_end: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(done_o && timeout_o));

  // R8: a start while busy leaves the held address alone
  a_r8_hold_sector: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && start_i) |=> $stable(sect_q));

endmodule

// File: tb/tb_erase_seq.sv
module tb_erase_seq;

  localparam int unsigned AW  = 20;
  localparam int unsigned STB = 3;
  localparam int unsigned GAP = 20;
  localparam int unsigned TO  = 3000;
  localparam logic [AW-1:0] U1 = 20'h555;
  localparam logic [AW-1:0] U2 = 20'h2AA;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] sector_addr_i;
  logic          busy_o, done_o, timeout_o, bus_req_o;
  logic          bus_gnt_i;
  logic [AW-1:0] bus_addr_o;
  logic [7:0]    bus_wdata_o, bus_rdata_i;
  logic          bus_wdata_oe_o, bus_we_n_o, bus_oe_n_o;

  always #4 clk = ~clk;

  erase_seq #(
    .ADDR_W        (AW),
    .STROBE_CLKS   (STB),
    .POLL_GAP_CLKS (GAP),
    .TIMEOUT_CLKS  (TO),
    .UNLOCK1_ADDR  (U1),
    .UNLOCK2_ADDR  (U2)
  ) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .sector_addr_i  (sector_addr_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .timeout_o      (timeout_o),
    .bus_req_o      (bus_req_o),
    .bus_gnt_i      (bus_gnt_i),
    .bus_addr_o     (bus_addr_o),
    .bus_wdata_o    (bus_wdata_o),
    .bus_wdata_oe_o (bus_wdata_oe_o),
    .bus_we_n_o     (bus_we_n_o),
    .bus_oe_n_o     (bus_oe_n_o),
    .bus_rdata_i    (bus_rdata_i)
  );

  int checks = 0;
  int fails  = 0;
  int cyc = 0;
  int wr_n = 0, rd_n = 0, need = 1;
  int stb_lo = 0, gap_lo = 0;
  int done_cnt = 0, tout_cnt = 0;
  int last_wr_cyc = 0, tout_cyc = 0;
  bit in_op = 0;
  logic [AW-1:0] wr_a [8];
  logic [7:0]    wr_d [8];
  logic [AW-1:0] exp_sect = '0, last_rd_addr = '0;
  logic [6:0]    junk = '0;
  logic          p_we = 1'b1, p_oe = 1'b1, p_doe = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic [7:0]    p_data = '0;

  // flash model: the need-th poll reports completion on bit 7
  assign bus_rdata_i = {(rd_n + 1 >= need), junk};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input int i, input logic [AW-1:0] s);
    case (i)
      0, 2, 3: return U1;
      1, 4:    return U2;
      default: return s;
    endcase
  endfunction

  function automatic logic [7:0] exp_data(input int i);
    case (i)
      0, 3:    return 8'hAA;
      1, 4:    return 8'h55;
      2:       return 8'h80;
      default: return 8'h30;
    endcase
  endfunction

  // bus monitor and arbiter, sampled between clock edges
  always @(negedge clk) begin
    cyc++;
    if (!bus_we_n_o && !bus_oe_n_o) chk(0, "R10 strobes overlap", 1, 0);
    if ((!bus_we_n_o || !bus_oe_n_o) && !(bus_gnt_i && bus_req_o))
      chk(0, "R10 strobe without grant", bus_gnt_i, 1);
    if (!bus_req_o && (!bus_we_n_o || !bus_oe_n_o || bus_wdata_oe_o))
      chk(0, "R4 activity on released bus", bus_wdata_oe_o, 0);

    if (p_we && !bus_we_n_o) begin
      stb_lo = 1;
      chk(p_doe && bus_addr_o == p_addr && bus_wdata_o == p_data,
          "R3 write setup", bus_addr_o, p_addr);
    end else if (!bus_we_n_o) begin
      stb_lo++;
      if (bus_addr_o != p_addr || bus_wdata_o != p_data)
        chk(0, "R3 write not stable", bus_wdata_o, p_data);
    end
    if (!p_we && bus_we_n_o) begin
      chk(stb_lo == STB, "R3 write strobe width", stb_lo, STB);
      chk(bus_wdata_oe_o, "R3 write data hold", bus_wdata_oe_o, 1);
      if (wr_n < 8) begin
        wr_a[wr_n] = p_addr;
        wr_d[wr_n] = p_data;
      end
      wr_n++;
      last_wr_cyc = cyc;
    end

    if (p_oe && !bus_oe_n_o) begin
      stb_lo = 1;
    end else if (!bus_oe_n_o) begin
      stb_lo++;
      if (bus_addr_o != p_addr) chk(0, "R5 read address not stable", bus_addr_o, p_addr);
    end
    if (!bus_oe_n_o && bus_wdata_oe_o) chk(0, "R5 data driven during read", 1, 0);
    if (!p_oe && bus_oe_n_o) begin
      chk(stb_lo == STB, "R5 read strobe width", stb_lo, STB);
      chk(p_addr == exp_sect, "R5 poll address", p_addr, exp_sect);
      last_rd_addr = p_addr;
      rd_n++;
      junk = 7'($urandom);
    end

    if (!bus_req_o) gap_lo++;
    else begin
      if (gap_lo > 0 && in_op && wr_n >= 6)
        chk(gap_lo == GAP + 1, "R4 poll gap", gap_lo, GAP + 1);
      gap_lo = 0;
    end

    if (done_o) done_cnt++;
    if (timeout_o) begin
      tout_cnt++;
      tout_cyc = cyc;
    end

    p_we   = bus_we_n_o;
    p_oe   = bus_oe_n_o;
    p_doe  = bus_wdata_oe_o;
    p_addr = bus_addr_o;
    p_data = bus_wdata_o;
    bus_gnt_i = bus_req_o ? (bus_gnt_i | ($urandom_range(0, 2) == 0)) : 1'b0;
  end

  task automatic start_op(input logic [AW-1:0] a);
    @(negedge clk);
    wr_n = 0; rd_n = 0; done_cnt = 0; tout_cnt = 0;
    exp_sect = a; in_op = 1;
    sector_addr_i = a;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && bus_req_o && bus_we_n_o && bus_oe_n_o, "R1 start raises busy and request",
        {busy_o, bus_req_o}, 3);
  endtask

  task automatic wait_end(input int limit);
    for (int i = 0; i < limit && done_cnt == 0 && tout_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_erase(input logic [AW-1:0] a, input int n, input bit mid_start);
    need = n;
    start_op(a);
    if (mid_start) begin
      for (int i = 0; i < 2000 && rd_n < 1; i++) @(negedge clk);
      sector_addr_i = ~a;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_end(TO + 500);
    chk(done_cnt == 1, "R6 one done pulse", done_cnt, 1);
    chk(tout_cnt == 0, "R7 no timeout on success", tout_cnt, 0);
    chk(wr_n == 6, "R2 six launch writes", wr_n, 6);
    for (int i = 0; i < 6; i++)
      chk(wr_a[i] == exp_addr(i, a) && wr_d[i] == exp_data(i), "R2 launch write contents",
          {wr_a[i], wr_d[i]}, {exp_addr(i, a), exp_data(i)});
    chk(rd_n == n, "R6 polls until bit 7 set", rd_n, n);
    chk(!busy_o && !bus_req_o, "R6 idle after done", busy_o, 0);
    if (mid_start)
      chk(last_rd_addr == a && rd_n == n, "R8 start while busy ignored", last_rd_addr, a);
    in_op = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int delta;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; start_i = 1'b0; sector_addr_i = '0; bus_gnt_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !bus_req_o && bus_we_n_o && bus_oe_n_o && !bus_wdata_oe_o &&
        !done_o && !timeout_o, "R9 reset state", busy_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corners
    run_erase('0, 1, 1'b0);
    run_erase('1, 1, 1'b0);
    run_erase(20'h3C000, 3, 1'b1);

    // random mix
    for (int k = 0; k < 8; k++) begin
      logic [AW-1:0] a;
      int n;
      a = AW'($urandom);
      n = $urandom_range(1, 4);
      run_erase(a, n, (k % 3 == 1) && n >= 2);
    end

    // R7: the flash never finishes
    need = 1_000_000;
    start_op(20'h7A5A5);
    wait_end(TO + 200);
    delta = tout_cyc - last_wr_cyc;
    chk(tout_cnt == 1, "R7 timeout pulse", tout_cnt, 1);
    chk(done_cnt == 0, "R7 no done on timeout", done_cnt, 0);
    chk(delta >= TO + 2 && delta <= TO + STB + 6, "R7 timeout latency", delta, TO + 2);
    chk(rd_n >= 1 && !busy_o && !bus_req_o, "R7 idle after timeout", busy_o, 0);
    in_op = 0;

    // R9: reset during an erase, then relaunch
    need = 50;
    start_op(20'h12345);
    for (int i = 0; i < 2000 && rd_n < 2; i++) @(negedge clk);
    for (int i = 0; i < 100 && bus_req_o; i++) @(negedge clk);
    rst_n = 1'b0;
    in_op = 0;
    repeat (2) @(negedge clk);
    chk(!busy_o && !bus_req_o && bus_we_n_o && bus_oe_n_o && !bus_wdata_oe_o,
        "R9 reset forces idle", busy_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_erase(20'h12345, 2, 1'b0);
    chk(wr_n == 6 && done_cnt == 1, "R9 relaunch runs all six writes", wr_n, 6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule